// File: doc/BRIEF.md
# Transmit Mailbox Priority Selector

This block chooses which pending transmit mailbox a CAN-style controller sends next. Each mailbox from 1 to 31 can raise a pending request and carries an 11-bit identifier. The block outputs the index of the winning mailbox and a flag that says whether any mailbox won. Mailbox 0 never takes part in the selection.

Two priority schemes are available. In identifier order, the winner is the mailbox that would win bus arbitration against the others if all of them started sending together. Dominant zero bits win on the bus, so this is the smallest identifier. In mailbox order, the highest mailbox number wins. A configuration write picks the scheme. The write is accepted only while the controller reports that it is in its reset or halt mode, so the ordering cannot change while the controller takes part in bus traffic.

The choice is registered. It follows the request and identifier inputs one clock later.

Top module: `txmb_pick`

## Requirements
- R1: After the synchronous reset, `sel_valid` is 0, `sel_idx` is 0 and `prio_mode` is 0, which selects identifier order.
- R2: With `prio_mode` = 0, the selected mailbox is the pending mailbox with the numerically smallest identifier. Mailbox i's identifier is `tx_ids[i*11 +: 11]`.
- R3: With `prio_mode` = 0, when several pending mailboxes share the smallest identifier, the one with the highest mailbox number is selected.
- R4: With `prio_mode` = 1, the pending mailbox with the highest number is selected and identifiers have no effect. Mailbox 31 ranks highest and mailbox 1 lowest.
- R5: Bit 0 of `tx_pend` (mailbox 0) has no effect on the selection.
- R6: When no mailbox from 1 to 31 is pending, `sel_valid` is 0 and `sel_idx` is 0.
- R7: `sel_valid` and `sel_idx` reflect the request, identifier and mode values that were present at the previous rising clock edge.
- R8: A write (`mode_wr` = 1 with value `mode_wdata`) is taken while `cfg_open` = 1. `prio_mode` shows the new value after the next edge, and the selection uses it from the edge after that.
- R9: A write while `cfg_open` = 0 is ignored. `prio_mode` and the selection ordering stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_open | input | 1 | High while the controller is in its reset or halt mode |
| mode_wr | input | 1 | Write strobe for the priority mode |
| mode_wdata | input | 1 | Mode value to write: 0 for identifier order, 1 for mailbox order |
| tx_pend | input | 32 | Pending transmit requests, one bit per mailbox (bit 0 is unused) |
| tx_ids | input | 352 | Identifiers, 11 bits per mailbox, with mailbox i at bits i*11 and up |
| prio_mode | output | 1 | Current priority mode |
| sel_valid | output | 1 | A mailbox is selected |
| sel_idx | output | 5 | Number of the selected mailbox |

## Verification
Each new set of requests and identifiers gives a selection that is due one rising edge later, and the check for it is made just after that edge. A mode write changes `prio_mode` on that same edge. The selection still follows the old ordering on that edge and switches to the new ordering on the next one. The scoreboard pushes exactly one expected item for each edge it drives and pops one item for each edge it observes, so every comparison falls on the cycle in which the result is due. Random request and identifier patterns, ties, a request on mailbox 0 alone, an empty request set, and both accepted and refused mode writes are each compared in this way.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  typedef enum logic {
    PRIO_BY_ID   = 1'b0,
    PRIO_BY_MBOX = 1'b1
  } prio_mode_e;
endpackage

// File: rtl/txmb_mode_lock.sv
module txmb_mode_lock
  import txmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       open_i,
  input  logic       wr_i,
  input  logic       wdata_i,
  output prio_mode_e mode_o
);
  prio_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= PRIO_BY_ID;
    else if (wr_i && open_i)
      mode_q <= prio_mode_e'(wdata_i);
  end

  assign mode_o = mode_q;

  // R9: a closed configuration window freezes the mode
  p_mode_locked_r9: assert property (@(posedge clk) disable iff (rst)
    !open_i |=> $stable(mode_q));
  // R8: an accepted write lands on the next edge
  p_mode_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (open_i && wr_i) |=> (mode_q == prio_mode_e'($past(wdata_i))));
endmodule

// File: rtl/txmb_arb_tree.sv
module txmb_arb_tree
  import txmb_pkg::*;
#(
  parameter int N_MB  = 32,
  parameter int ID_W  = 11,
  parameter int IDX_W = $clog2(N_MB)
) (
  input  logic [N_MB-1:0]      req_i,
  input  logic [N_MB*ID_W-1:0] ids_i,
  input  prio_mode_e           mode_i,
  output logic                 win_v_o,
  output logic [IDX_W-1:0]     win_idx_o
);
  localparam int LEAVES = 1 << IDX_W;
  localparam int KW     = ID_W + IDX_W;

  // heap-ordered tree: node n has children 2n and 2n+1, root is 1
  logic             nv [2*LEAVES-1:1];
  logic [KW-1:0]    nk [2*LEAVES-1:1];
  logic [IDX_W-1:0] ni [2*LEAVES-1:1];

  // bigger key wins: inverted id ranks the smallest id highest,
  // and the index in the low bits breaks ties toward higher numbers
  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l >= 1 && l < N_MB) begin : g_live
      assign nv[LEAVES+l] = req_i[l];
      assign ni[LEAVES+l] = IDX_W'(l);
      assign nk[LEAVES+l] = (mode_i == PRIO_BY_MBOX)
                          ? {{ID_W{1'b0}}, IDX_W'(l)}
                          : {~ids_i[l*ID_W +: ID_W], IDX_W'(l)};
    end else begin : g_dead
      assign nv[LEAVES+l] = 1'b0;
      assign ni[LEAVES+l] = '0;
      assign nk[LEAVES+l] = '0;
    end
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_l;
    assign take_l = nv[2*n] && (!nv[2*n+1] || (nk[2*n] > nk[2*n+1]));
    assign nv[n]  = nv[2*n] | nv[2*n+1];
    assign nk[n]  = take_l ? nk[2*n] : nk[2*n+1];
    assign ni[n]  = take_l ? ni[2*n] : ni[2*n+1];
  end

  assign win_v_o   = nv[1];
  assign win_idx_o = nv[1] ? ni[1] : '0;
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick
  import txmb_pkg::*;
#(
  parameter int N_MB  = 32,
  parameter int ID_W  = 11,
  parameter int IDX_W = $clog2(N_MB)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_open,
  input  logic                 mode_wr,
  input  logic                 mode_wdata,
  input  logic [N_MB-1:0]      tx_pend,
  input  logic [N_MB*ID_W-1:0] tx_ids,
  output logic                 prio_mode,
  output logic                 sel_valid,
  output logic [IDX_W-1:0]     sel_idx
);
  prio_mode_e       mode;
  logic             win_v;
  logic [IDX_W-1:0] win_idx;

  txmb_mode_lock u_lock (
    .clk     (clk),
    .rst     (rst),
    .open_i  (cfg_open),
    .wr_i    (mode_wr),
    .wdata_i (mode_wdata),
    .mode_o  (mode)
  );

  txmb_arb_tree #(.N_MB(N_MB), .ID_W(ID_W), .IDX_W(IDX_W)) u_tree (
    .req_i     (tx_pend),
    .ids_i     (tx_ids),
    .mode_i    (mode),
    .win_v_o   (win_v),
    .win_idx_o (win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else begin
      sel_valid <= win_v;
      sel_idx   <= win_idx;
    end
  end

  assign prio_mode = mode;

  // R6: nothing pending among mailboxes 1.. gives an empty result
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_pend[N_MB-1:1] == '0) |=> (!sel_valid && sel_idx == '0));
  // R7: any live request produces a valid pick one edge later
  p_pick_due_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_pend[N_MB-1:1] != '0) |=> sel_valid);
  // R5: mailbox 0 is never chosen
  p_no_mbox0_r5: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (sel_idx != '0));
  // R4: in mailbox order the top mailbox always wins when pending
  p_top_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == PRIO_BY_MBOX && tx_pend[N_MB-1]) |=> (sel_idx == IDX_W'(N_MB-1)));
endmodule

// File: tb/txmb_pick_bench.sv
module txmb_pick_bench;
  localparam int PERIOD = 10;
  localparam int NMB    = 32;
  localparam int IDW    = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_open = 1'b0, mode_wr = 1'b0, mode_wdata = 1'b0;
  logic [NMB-1:0]  tx_pend = '0;
  logic [NMB*IDW-1:0] tx_ids;
  logic            prio_mode, sel_valid;
  logic [4:0]      sel_idx;

  logic [IDW-1:0]  cur_id [NMB];
  logic [IDW-1:0]  nxt_id [NMB];

  always #(PERIOD/2) clk = ~clk;

  always_comb
    for (int i = 0; i < NMB; i++) tx_ids[i*IDW +: IDW] = cur_id[i];

  txmb_pick u_txmb_pick (
    .clk(clk), .rst(rst), .cfg_open(cfg_open), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .tx_pend(tx_pend), .tx_ids(tx_ids),
    .prio_mode(prio_mode), .sel_valid(sel_valid), .sel_idx(sel_idx)
  );

  int compared = 0, mismatched = 0;
  logic [6:0] exp_q [$];
  string      tag_q [$];
  logic       mode_exp = 1'b0;

  // bench model: identifier order picks the smallest id, ties go to the
  // higher mailbox; mailbox order picks the highest pending number
  function automatic logic [5:0] model(input logic [NMB-1:0] p, input logic m);
    logic [IDW-1:0] best_id = '1;
    logic           found = 1'b0;
    logic [4:0]     best = '0;
    for (int i = 1; i < NMB; i++) begin
      if (p[i]) begin
        if (m || !found || nxt_id[i] <= best_id) begin
          best_id = nxt_id[i];
          best = 5'(i);
        end
        found = 1'b1;
      end
    end
    return {found, best};
  endfunction

  task automatic step(input logic [NMB-1:0] p, input logic open,
                      input logic wr, input logic wv, input string tag);
    @(negedge clk);
    tx_pend = p; cfg_open = open; mode_wr = wr; mode_wdata = wv;
    for (int i = 0; i < NMB; i++) cur_id[i] = nxt_id[i];
    if (wr && open) begin
      exp_q.push_back({model(p, mode_exp), wv});
      mode_exp = wv;
    end else begin
      exp_q.push_back({model(p, mode_exp), mode_exp});
    end
    tag_q.push_back(tag);
  endtask

  // monitor: one pop per edge, sampled just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [6:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if ({sel_valid, sel_idx, prio_mode} !== e) begin
          mismatched++;
          $display("FAIL %s: got valid=%0b idx=%0d mode=%0b, expected valid=%0b idx=%0d mode=%0b",
                   t, sel_valid, sel_idx, prio_mode, e[6], e[5:1], e[0]);
        end
      end
    end
  end

  initial begin
    #(PERIOD*200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < NMB; i++) begin
      nxt_id[i] = IDW'(100 + i);
      cur_id[i] = nxt_id[i];
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compared++;
    if ({sel_valid, sel_idx, prio_mode} !== 7'b0) begin
      mismatched++;
      $display("FAIL R1 reset: got %0b/%0d/%0b, expected 0/0/0", sel_valid, sel_idx, prio_mode);
    end

    step('0, 0, 0, 0, "R6 nothing pending");
    step(32'h1, 0, 0, 0, "R5 mailbox 0 alone");
    nxt_id[5] = 11'h010; nxt_id[9] = 11'h7FF; nxt_id[20] = 11'h011;
    step(32'h0010_0221, 0, 0, 0, "R2 smallest id wins");
    nxt_id[0] = 11'h000;
    step(32'h0010_0221, 0, 0, 0, "R5 mailbox 0 id ignored");
    nxt_id[7] = 11'h010;
    step(32'h0010_02A0, 0, 0, 0, "R3 tie to higher mailbox");
    nxt_id[31] = 11'h3; nxt_id[30] = 11'h3;
    step(32'hC000_0000, 0, 0, 0, "R3 tie at top");
    step(32'h0000_0002, 0, 0, 0, "R7 single low request");
    step(32'h0000_0002, 0, 1, 1, "R9 closed write refused");
    step(32'h0010_0221, 0, 0, 0, "R9 order kept after refused write");
    step(32'h0010_0221, 1, 1, 1, "R8 write taken, old order this edge");
    step(32'h0010_0221, 0, 0, 0, "R8 new order in use");
    step(32'h0000_0222, 0, 0, 0, "R4 highest number wins");
    step(32'h8000_0002, 0, 1, 0, "R9 closed write refused in mbox mode");
    step(32'h8000_0002, 0, 0, 0, "R4 mailbox 31 top");
    step('0, 0, 0, 0, "R6 empty in mbox mode");
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < NMB; i++) nxt_id[i] = IDW'($urandom_range(0, 15));
      step($urandom(), 0, 0, 0, mode_exp ? "R4 random" : "R2 random");
    end
    step(32'h0000_0F0F, 1, 1, 0, "R8 write back to id order");
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < NMB; i++) nxt_id[i] = IDW'($urandom_range(0, 7));
      step($urandom(), 0, 0, 0, "R2 R3 random ids");
    end
    step('0, 0, 0, 0, "R6 final idle");
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule